// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Capture

This block is a 16-bit up-counter that advances on a timer-tick enable. It has two compare registers and one capture register. A CPU reaches all four 16-bit registers through an 8-bit register port. The CPU moves each 16-bit value as two byte accesses. A single shared high-byte holding latch makes sure both halves move together, so the CPU never sees or writes a half-updated value.

On every tick the counter is checked against both compare registers, and a matching channel raises a one-cycle match pulse that can serve as an interrupt request. When the CPU loads the counter, matches on the next tick are suppressed, so a freshly written value does not fire an immediate match. A rising edge on the capture pin, or on an alternate comparator input, copies the running count into the capture register. The selected event input first passes through a two-flop synchronizer. The capture register can also be chosen as the counting ceiling, so that the period can be set either by capture or by software.

Top module: `timer16_capture`

## Requirements
- R1: After reset every register, the holding latch, `rdata`, `match_a` and `match_b` are 0.
- R2: Byte map: address 0/1 = counter low/high, 2/3 = compare A low/high, 4/5 = compare B low/high, 6/7 = capture low/high. A write to an odd (high) address only loads the holding latch. A write to the even (low) address commits {latch, wdata} to the 16-bit register in one cycle.
- R3: The holding latch is shared, so a high byte written toward one register is committed by a low-byte write to any other register.
- R4: With `rd_en` high, a read of a low address returns that register's low byte combinationally, and the clock edge copies its high byte into the latch. A read of a high address returns the latch, unaffected by later register changes.
- R5: The counter increments by one on each clock with `tick` high and holds otherwise. A CPU commit to the counter takes priority over a tick in the same cycle.
- R6: When a tick occurs with counter equal to compare A, `match_a` is high for exactly the next clock cycle.
- R7: When a tick occurs with counter equal to compare B, `match_b` is high for exactly the next clock cycle.
- R8: After a CPU commit to the counter, the first following tick produces no match on either channel.
- R9: With `cap_is_top` = 0, a tick at count 0xFFFF wraps the counter to 0.
- R10: With `cap_is_top` = 1, a tick while the counter equals the capture register loads 0.
- R11: A rising edge of the selected event input (`sel_alt` = 0: `cap_pin`, 1: `cmp_evt`) loads the current count into the capture register within three clock cycles.
- R12: Edges on the event input that is not selected leave the capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| sel_alt | input | 1 | Capture source: 0 pin, 1 comparator |
| cap_is_top | input | 1 | Use capture register as counting ceiling |
| cap_pin | input | 1 | Asynchronous capture event pin |
| cmp_evt | input | 1 | Asynchronous alternate comparator event |
| addr | input | 3 | Byte register address |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, 0 when not reading |
| match_a | output | 1 | Compare A match pulse |
| match_b | output | 1 | Compare B match pulse |

## Verification
Compare matching is tried with three counter preloads. The first approaches a compare value over several ticks, which separates a real match from the blocked tick. The second lands exactly on the compare value at the write, which shows that suppression is applied. The third walks on to the second channel, which shows that the channels are independent. Byte accesses cross registers on purpose: a high byte written to one register and committed through another exposes a private latch, and a tick between the low and high read exposes a non-atomic read. Capture is driven from each source in turn, with the other source pulsed as well, which tells the selection apart from an OR of both inputs.

// File: rtl/timer16_capture.sv
module timer16_capture #(
  parameter int BW = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sel_alt,
  input  logic          cap_is_top,
  input  logic          cap_pin,
  input  logic          cmp_evt,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic          match_a,
  output logic          match_b
);
  localparam int DW = 2 * BW;
  localparam logic [DW-1:0] ALL1 = {DW{1'b1}};

  logic [DW-1:0] cnt, cmp_a, cmp_b, cap;
  logic [BW-1:0] hold;
  logic          blk;
  logic [SYNC-1:0] pin_s, alt_s;
  logic          evt_d;

  wire lo_wr   = wr_en && !addr[0];
  wire hi_wr   = wr_en &&  addr[0];
  wire lo_rd   = rd_en && !addr[0];
  wire [DW-1:0] wval = {hold, wdata};
  wire cnt_wr  = lo_wr && addr[2:1] == 2'd0;
  wire evt     = sel_alt ? alt_s[SYNC-1] : pin_s[SYNC-1];
  wire evt_edge = evt && !evt_d;
  wire at_top  = cap_is_top ? (cnt == cap) : (cnt == ALL1);

  logic [DW-1:0] sel_reg;
  always_comb begin
    case (addr[2:1])
      2'd0:    sel_reg = cnt;
      2'd1:    sel_reg = cmp_a;
      2'd2:    sel_reg = cmp_b;
      default: sel_reg = cap;
    endcase
  end

  assign rdata = !rd_en ? '0 : (addr[0] ? hold : sel_reg[BW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (hi_wr) begin
      hold <= wdata;
    end else if (lo_rd) begin
      hold <= sel_reg[DW-1:BW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (cnt_wr) begin
      cnt <= wval;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= at_top ? '0 : cnt + 1'b1;
      blk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_a <= 1'b0;
      match_b <= 1'b0;
    end else begin
      match_a <= tick && !blk && !cnt_wr && cnt == cmp_a;
      match_b <= tick && !blk && !cnt_wr && cnt == cmp_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
    end else if (lo_wr) begin
      if (addr[2:1] == 2'd1) cmp_a <= wval;
      if (addr[2:1] == 2'd2) cmp_b <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s <= '0;
      alt_s <= '0;
      evt_d <= 1'b0;
    end else begin
      pin_s <= {pin_s[SYNC-2:0], cap_pin};
      alt_s <= {alt_s[SYNC-2:0], cmp_evt};
      evt_d <= evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap <= '0;
    end else if (evt_edge) begin
      cap <= cnt;
    end else if (lo_wr && addr[2:1] == 2'd3) begin
      cap <= wval;
    end
  end
endmodule

module timer16_capture_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cap_is_top,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] cap,
  input logic          match_a,
  input logic          match_b
);
  wire cw = wr_en && addr == 3'd0;
  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (cw) pend <= 1'b1;
    else if (tick) pend <= 1'b0;
  end

  AST_MATCH_A_TICK: assert property (@(posedge clk) disable iff (!rst_n) match_a |-> $past(tick)); // R6
  AST_MATCH_B_TICK: assert property (@(posedge clk) disable iff (!rst_n) match_b |-> $past(tick)); // R7
  AST_BLOCKED_TICK: assert property (@(posedge clk) disable iff (!rst_n) (pend && tick) |=> (!match_a && !match_b)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !cw) |=> $stable(cnt)); // R5
  AST_WRAP_FULL: assert property (@(posedge clk) disable iff (!rst_n) (tick && !cw && !cap_is_top && cnt == {DW{1'b1}}) |=> cnt == '0); // R9
  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n) (tick && !cw && cap_is_top && cnt == cap) |=> cnt == '0); // R10
endmodule

bind timer16_capture timer16_capture_chk #(.DW(2*BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cap_is_top(cap_is_top),
  .wr_en(wr_en), .addr(addr), .cnt(cnt), .cap(cap),
  .match_a(match_a), .match_b(match_b)
);

// File: tb/timer16_capture_tb.sv
module timer16_capture_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, sel_alt = 0, cap_is_top = 0;
  logic cap_pin = 0, cmp_evt = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic match_a, match_b;
  int errs = 0, checks = 0, na = 0, nb = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  timer16_capture dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel_alt(sel_alt), .cap_is_top(cap_is_top),
    .cap_pin(cap_pin), .cmp_evt(cmp_evt), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .match_a(match_a), .match_b(match_b)
  );

  always @(negedge clk) begin
    if (match_a) na++;
    if (match_b) nb++;
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errs++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo + 3'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1 addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic rd16(input logic [2:0] lo, input logic [15:0] e, input string t);
    rd(lo, e[7:0], t);
    rd(lo + 3'd1, e[15:8], t);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1;
      @(posedge clk); #1 tick = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk);
    chk("R1 outputs", {rdata, match_a, match_b}, 0);
    #1 rst_n = 1;
    for (int a = 0; a < 8; a += 2) rd16(a[2:0], 16'h0000, "R1 reset regs");

    wr16(3'd2, 16'h1234);
    rd16(3'd2, 16'h1234, "R2 write commit");
    wr(3'd3, 8'hAB);
    wr(3'd4, 8'hCD);
    rd16(3'd4, 16'hABCD, "R3 shared latch");
    rd16(3'd2, 16'h1234, "R3 other untouched");

    wr16(3'd0, 16'h00FF);
    rd(3'd0, 8'hFF, "R4 low read");
    ticks(1);
    rd(3'd1, 8'h00, "R4 latched high");
    rd16(3'd0, 16'h0100, "R5 increment");
    idle(4);
    rd16(3'd0, 16'h0100, "R5 hold without tick");

    wr16(3'd2, 16'h0010);
    wr16(3'd4, 16'h0012);
    wr16(3'd0, 16'h000E);
    na = 0; nb = 0;
    ticks(3);
    idle(2);
    chk("R6 match A count", na, 1);
    chk("R7 no B yet", nb, 0);
    ticks(2);
    idle(2);
    chk("R7 match B count", nb, 1);
    chk("R6 single pulse", na, 1);

    wr16(3'd0, 16'h0010);
    na = 0;
    ticks(1);
    idle(2);
    chk("R8 blocked tick", na, 0);
    wr16(3'd0, 16'h0012);
    nb = 0;
    ticks(1);
    idle(2);
    chk("R8 blocked tick B", nb, 0);

    wr16(3'd0, 16'hFFFF);
    ticks(1);
    rd16(3'd0, 16'h0000, "R9 full wrap");

    wr16(3'd6, 16'h0005);
    cap_is_top = 1;
    wr16(3'd0, 16'h0004);
    ticks(1);
    rd16(3'd0, 16'h0005, "R10 reach top");
    ticks(1);
    rd16(3'd0, 16'h0000, "R10 top wrap");
    cap_is_top = 0;

    wr16(3'd0, 16'h3456);
    #0 cap_pin = 1;
    idle(4);
    cap_pin = 0;
    rd16(3'd6, 16'h3456, "R11 pin capture");
    sel_alt = 1;
    idle(4);
    wr16(3'd0, 16'h789A);
    cap_pin = 1;
    idle(4);
    cap_pin = 0;
    idle(2);
    rd16(3'd6, 16'h3456, "R12 pin ignored");
    cmp_evt = 1;
    idle(4);
    cmp_evt = 0;
    rd16(3'd6, 16'h789A, "R11 alt capture");

    idle(3);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule